// File: doc/BRIEF.md
# Multi-Instance MMU Enable/Disable Sequencer

This block takes a group of identical MMU register blocks through a safe switch-on or switch-off procedure. A pulse on the enable or disable request starts a run. The block then uses a single shared register port to write command words to each active instance in turn. It finishes every phase on all instances before it starts the next phase, and it waits a programmable number of settle cycles after each phase. At the end of a run it raises a one-cycle done pulse together with a pass/fail flag.

Before an enable, the block reads the status of every active instance. If paging is already on everywhere, the run ends at once. Otherwise the instances are stalled, reset, reloaded with the saved directory-table base, flushed, given an interrupt enable mask, switched to paging and released. A final status sweep then decides pass or fail. A disable runs only when the last enable left the group marked as paged. A zero base value read back from instance 0 aborts the disable.

Top module: `mmu_seq_top`

## Requirements
- R1: After reset, busy, done and bus_req are low.
- R2: An enable run first reads the status register (select 1) of each active instance, in index order. If bit 0 (paging on) is set in all of them, the run ends with pass=1 and performs no write.
- R3: Otherwise the enable writes, in this order: command register (select 2) value 2 (stall) to every instance; command 6 (reset) to every instance; then, for each instance in turn, base register (select 0) with the latched base value, command 4 (flush) and interrupt enable register (select 3) value 3; command 0 (paging on) to every instance; command 3 (stall release) to every instance. It then reads the status of every instance.
- R4: After the last access of each write phase the port stays idle for exactly settle_cycles+1 cycles before the next phase starts. An enable has five such gaps and a disable has three.
- R5: An enable that ran its write phases passes only if bit 0 of every active instance's final status is set. Otherwise pass=0.
- R6: A disable request when the group is not marked paged ends with pass=1 and no bus access. The group becomes marked paged after a passing enable. It stops being marked paged after a failing enable or a completed disable.
- R7: A disable on a paged group first reads the base register of instance 0. If that value is zero, the run ends with pass=0, does no write and leaves the group marked paged.
- R8: A disable with a nonzero base writes command 2 to every instance, then command 1 (paging off) to every instance, then command 3 to every instance, and ends with pass=1.
- R9: Each access is held on the port, unchanged, until bus_ack. The instance index and step advance only on bus_ack.
- R10: busy is high from the cycle after an accepted request through the done cycle. done lasts exactly one cycle, and pass is valid with it.
- R11: Requests that arrive while busy is high are ignored.
- R12: If enable and disable requests arrive in the same idle cycle, the enable is performed.
- R13: An instance count of 0 is treated as 1, and a count above the number of instances is treated as that number. Only instances below the effective count are accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Start-enable request pulse |
| dis_req | input | 1 | Start-disable request pulse |
| base_val | input | 32 | Saved directory-table base to restore |
| inst_cnt | input | CNT_W | Number of active instances |
| settle_cycles | input | SETTLE_W | Settle delay after each phase, in cycles |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the run, valid with done |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_inst | output | IDX_W | Target instance index |
| bus_reg | output | 2 | Register select: 0 base, 1 status, 2 command, 3 interrupt enable |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access accepted; read data valid |
| bus_rdata | input | 32 | Read data |

## Verification
Two functions can meet in one cycle. The first is simultaneous enable and disable requests in an idle cycle. The bench raises both and expects the full enable access sequence and nothing from the disable path. The second is a new request that lands while a run is still busy, including in its first busy cycle. The bench pulses requests there and judges them ignored when the recorded access log, the result and the count of done pulses match a single run exactly.

// File: rtl/mmu_seq_pkg.sv
package mmu_seq_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        RG_BASE  = 2'd0,
        RG_STAT  = 2'd1,
        RG_CMD   = 2'd2,
        RG_IRQEN = 2'd3
    } reg_sel_e;

    localparam logic [DATA_W-1:0] OP_PG_ON   = 32'd0;
    localparam logic [DATA_W-1:0] OP_PG_OFF  = 32'd1;
    localparam logic [DATA_W-1:0] OP_HOLD    = 32'd2;
    localparam logic [DATA_W-1:0] OP_RELEASE = 32'd3;
    localparam logic [DATA_W-1:0] OP_FLUSH   = 32'd4;
    localparam logic [DATA_W-1:0] OP_RESET   = 32'd6;
    localparam logic [DATA_W-1:0] IRQ_EN_VAL = 32'h3;
    localparam int                STAT_PG    = 0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PROBE, ST_CHKBASE, ST_WRITE, ST_WAIT, ST_VERIFY, ST_FINISH
    } state_e;

    typedef enum logic [2:0] {
        PH_HOLD, PH_RESET, PH_RESTORE, PH_PGON, PH_PGOFF, PH_RELEASE
    } phase_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          rsel;
        logic [DATA_W-1:0] data;
    } access_t;

    function automatic phase_e next_phase(input logic dis_mode, input phase_e ph);
        case (ph)
            PH_HOLD:    return dis_mode ? PH_PGOFF : PH_RESET;
            PH_RESET:   return PH_RESTORE;
            PH_RESTORE: return PH_PGON;
            default:    return PH_RELEASE;
        endcase
    endfunction

    function automatic logic [1:0] phase_steps(input phase_e ph);
        return (ph == PH_RESTORE) ? 2'd3 : 2'd1;
    endfunction

    function automatic access_t phase_access(input phase_e ph, input logic [1:0] sub,
                                             input logic [DATA_W-1:0] base);
        access_t a;
        a.we   = 1'b1;
        a.rsel = RG_CMD;
        a.data = OP_HOLD;
        case (ph)
            PH_RESET:   a.data = OP_RESET;
            PH_PGON:    a.data = OP_PG_ON;
            PH_PGOFF:   a.data = OP_PG_OFF;
            PH_RELEASE: a.data = OP_RELEASE;
            PH_RESTORE: begin
                if (sub == 2'd0) begin
                    a.rsel = RG_BASE;
                    a.data = base;
                end else if (sub == 2'd1) begin
                    a.data = OP_FLUSH;
                end else begin
                    a.rsel = RG_IRQEN;
                    a.data = IRQ_EN_VAL;
                end
            end
            default:    a.data = OP_HOLD;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/mmu_seq_settle.sv
module mmu_seq_settle #(
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SETTLE_W-1:0] len,
    output logic                expired
);
    logic [SETTLE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mmu_seq_walk.sv
module mmu_seq_walk #(
    parameter int IDX_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       steps,
    output logic [IDX_W-1:0] idx,
    output logic [1:0]       sub,
    output logic             last
);
    logic sub_end;

    assign sub_end = (sub == steps - 2'd1);
    assign last    = sub_end && (idx == IDX_W'(count - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
            sub <= '0;
        end else if (step) begin
            if (sub_end) begin
                sub <= '0;
                idx <= idx + 1'b1;
            end else begin
                sub <= sub + 2'd1;
            end
        end
    end

    // R13
    idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        CNT_W'(idx) < count);
endmodule

// File: rtl/mmu_seq_fsm.sv
module mmu_seq_fsm
    import mmu_seq_pkg::*;
#(
    parameter int N_INST   = 4,
    parameter int IDX_W    = 2,
    parameter int CNT_W    = 3,
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_req,
    input  logic                dis_req,
    input  logic [DATA_W-1:0]   base_val,
    input  logic [CNT_W-1:0]    cnt_in,
    input  logic [SETTLE_W-1:0] settle_in,
    input  logic [IDX_W-1:0]    walk_idx,
    input  logic [1:0]          walk_sub,
    input  logic                walk_last,
    input  logic                settle_done,
    input  logic                bus_ack,
    input  logic [DATA_W-1:0]   bus_rdata,
    output logic                walk_clear,
    output logic                walk_step,
    output logic [1:0]          walk_steps,
    output logic [CNT_W-1:0]    count,
    output logic                settle_load,
    output logic [SETTLE_W-1:0] settle_len,
    output logic                bus_req,
    output access_t             acc,
    output logic                busy,
    output logic                done,
    output logic                pass
);
    state_e              state;
    phase_e              phase;
    logic                dis_mode;
    logic                paged_q;
    logic                acc_q;
    logic                res_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [DATA_W-1:0]   base_q;
    logic [SETTLE_W-1:0] settle_q;
    logic                pg_bit;
    logic                all_pg;

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
        if (c == '0)
            return CNT_W'(1);
        if (c > CNT_W'(N_INST))
            return CNT_W'(N_INST);
        return c;
    endfunction

    assign pg_bit = bus_rdata[STAT_PG];
    assign all_pg = acc_q & pg_bit;

    always_comb begin
        bus_req = (state == ST_PROBE) || (state == ST_CHKBASE) ||
                  (state == ST_WRITE) || (state == ST_VERIFY);
        if (state == ST_WRITE)
            acc = phase_access(phase, walk_sub, base_q);
        else begin
            acc.we   = 1'b0;
            acc.rsel = (state == ST_CHKBASE) ? RG_BASE : RG_STAT;
            acc.data = '0;
        end
    end

    assign walk_step   = bus_ack;
    assign walk_clear  = (state == ST_IDLE) || (state == ST_WAIT) ||
                         (bus_ack && (walk_last || state == ST_CHKBASE));
    assign walk_steps  = (state == ST_WRITE) ? phase_steps(phase) : 2'd1;
    assign count       = cnt_q;
    assign settle_load = (state == ST_WRITE) && bus_ack && walk_last;
    assign settle_len  = settle_q;
    assign busy        = (state != ST_IDLE);
    assign done        = (state == ST_FINISH);
    assign pass        = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_HOLD;
            dis_mode <= 1'b0;
            paged_q  <= 1'b0;
            acc_q    <= 1'b1;
            res_q    <= 1'b0;
            cnt_q    <= CNT_W'(1);
            base_q   <= '0;
            settle_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (en_req || dis_req) begin
                        cnt_q    <= clamp_cnt(cnt_in);
                        base_q   <= base_val;
                        settle_q <= settle_in;
                        acc_q    <= 1'b1;
                        phase    <= PH_HOLD;
                    end
                    if (en_req) begin
                        dis_mode <= 1'b0;
                        state    <= ST_PROBE;
                    end else if (dis_req) begin
                        dis_mode <= 1'b1;
                        if (paged_q)
                            state <= ST_CHKBASE;
                        else begin
                            res_q <= 1'b1;
                            state <= ST_FINISH;
                        end
                    end
                end
                ST_PROBE: begin
                    if (bus_ack) begin
                        acc_q <= all_pg;
                        if (walk_last) begin
                            if (all_pg) begin
                                res_q   <= 1'b1;
                                paged_q <= 1'b1;
                                state   <= ST_FINISH;
                            end else
                                state <= ST_WRITE;
                        end
                    end
                end
                ST_CHKBASE: begin
                    if (bus_ack) begin
                        if (bus_rdata == '0) begin
                            res_q <= 1'b0;
                            state <= ST_FINISH;
                        end else
                            state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (bus_ack && walk_last)
                        state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (settle_done) begin
                        if (phase == PH_RELEASE) begin
                            if (dis_mode) begin
                                res_q   <= 1'b1;
                                paged_q <= 1'b0;
                                state   <= ST_FINISH;
                            end else begin
                                acc_q <= 1'b1;
                                state <= ST_VERIFY;
                            end
                        end else begin
                            phase <= next_phase(dis_mode, phase);
                            state <= ST_WRITE;
                        end
                    end
                end
                ST_VERIFY: begin
                    if (bus_ack) begin
                        acc_q <= all_pg;
                        if (walk_last) begin
                            res_q   <= all_pg;
                            paged_q <= all_pg;
                            state   <= ST_FINISH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(walk_idx) && $stable(acc));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R11
    start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(en_req || dis_req));

    // R4
    quiet_while_settling_chk: assert property (@(posedge clk) disable iff (rst)
        !settle_done |-> !bus_req);
endmodule

// File: rtl/mmu_seq_top.sv
module mmu_seq_top
    import mmu_seq_pkg::*;
#(
    parameter int  N_INST   = 4,
    parameter int  SETTLE_W = 16,
    localparam int IDX_W    = (N_INST > 1) ? $clog2(N_INST) : 1,
    localparam int CNT_W    = $clog2(N_INST + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_req,
    input  logic                dis_req,
    input  logic [31:0]         base_val,
    input  logic [CNT_W-1:0]    inst_cnt,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                busy,
    output logic                done,
    output logic                pass,
    output logic                bus_req,
    output logic                bus_we,
    output logic [IDX_W-1:0]    bus_inst,
    output logic [1:0]          bus_reg,
    output logic [31:0]         bus_wdata,
    input  logic                bus_ack,
    input  logic [31:0]         bus_rdata
);
    logic                walk_clear;
    logic                walk_step;
    logic [1:0]          walk_steps;
    logic [CNT_W-1:0]    count;
    logic [IDX_W-1:0]    walk_idx;
    logic [1:0]          walk_sub;
    logic                walk_last;
    logic                settle_load;
    logic [SETTLE_W-1:0] settle_len;
    logic                settle_done;
    access_t             acc;

    mmu_seq_fsm #(
        .N_INST(N_INST), .IDX_W(IDX_W), .CNT_W(CNT_W), .SETTLE_W(SETTLE_W)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .en_req(en_req), .dis_req(dis_req),
        .base_val(base_val), .cnt_in(inst_cnt), .settle_in(settle_cycles),
        .walk_idx(walk_idx), .walk_sub(walk_sub), .walk_last(walk_last),
        .settle_done(settle_done),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .walk_clear(walk_clear), .walk_step(walk_step), .walk_steps(walk_steps),
        .count(count),
        .settle_load(settle_load), .settle_len(settle_len),
        .bus_req(bus_req), .acc(acc),
        .busy(busy), .done(done), .pass(pass)
    );

    mmu_seq_walk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_walk (
        .clk(clk), .rst(rst),
        .clear(walk_clear), .step(walk_step),
        .count(count), .steps(walk_steps),
        .idx(walk_idx), .sub(walk_sub), .last(walk_last)
    );

    mmu_seq_settle #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk(clk), .rst(rst),
        .load(settle_load), .len(settle_len), .expired(settle_done)
    );

    assign bus_we    = acc.we;
    assign bus_reg   = acc.rsel;
    assign bus_wdata = acc.data;
    assign bus_inst  = walk_idx;

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> !busy && !done && !bus_req);
endmodule

// File: tb/test_mmu_seq_top.sv
`timescale 1ns/1ps
module test_mmu_seq_top;
    localparam int N = 4;
    localparam logic [1:0] S_BASE = 2'd0, S_STAT = 2'd1, S_CMD = 2'd2, S_IRQ = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_req = 1'b0, dis_req = 1'b0;
    logic [31:0] base_val = '0;
    logic [2:0]  inst_cnt = '0;
    logic [15:0] settle_cycles = '0;
    logic        busy, done, pass;
    logic        bus_req, bus_we, bus_ack;
    logic [1:0]  bus_inst, bus_reg;
    logic [31:0] bus_wdata, bus_rdata;

    always #2 clk = ~clk;

    mmu_seq_top i_mmu_seq_top (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
        .base_val(base_val), .inst_cnt(inst_cnt), .settle_cycles(settle_cycles),
        .busy(busy), .done(done), .pass(pass),
        .bus_req(bus_req), .bus_we(bus_we), .bus_inst(bus_inst), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // slave models
    logic        pg [N];
    logic        stall [N];
    logic        broken [N];
    logic [31:0] sbase [N];
    logic [31:0] sirq [N];
    logic [38:0] act_log [64];
    logic [38:0] exp_log [64];
    int          act_n, exp_n;
    int          total = 0, fails = 0;
    int          run_len = 0, w_cnt = 0, w_bad = 0;
    int          cur_settle = 0;
    int          done_cnt = 0;
    bit          paged_m = 0;
    bit          exp_pass;
    int          exp_waits;

    function automatic logic [38:0] ent(input int i, input logic we, input logic [1:0] r,
                                        input logic [31:0] d);
        return {i[3:0], r, we, d};
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            pg[i] = 0; stall[i] = 0; broken[i] = 0; sbase[i] = 32'h1000; sirq[i] = 0;
        end
        act_n = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            bus_ack <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= 1'b0;
            if (bus_req && !bus_ack && ($urandom % 2 == 0)) begin
                bus_ack <= 1'b1;
                if (act_n < 64) act_log[act_n] = ent(int'(bus_inst), bus_we, bus_reg,
                                                     bus_we ? bus_wdata : 32'd0);
                act_n++;
                if (!bus_we)
                    bus_rdata <= (bus_reg == S_BASE) ? sbase[bus_inst] :
                                 {29'd0, stall[bus_inst], 1'b0, pg[bus_inst]};
                else if (bus_reg == S_BASE) sbase[bus_inst] = bus_wdata;
                else if (bus_reg == S_IRQ)  sirq[bus_inst] = bus_wdata;
                else case (bus_wdata)
                    32'd0: pg[bus_inst] = !broken[bus_inst];
                    32'd1: pg[bus_inst] = 1'b0;
                    32'd2: stall[bus_inst] = 1'b1;
                    32'd3: stall[bus_inst] = 1'b0;
                    32'd6: begin pg[bus_inst] = 1'b0; sbase[bus_inst] = '0; sirq[bus_inst] = '0; end
                    default: ;
                endcase
            end
        end
    end

    // settle gap monitor
    always @(negedge clk) begin
        if (!rst && busy && !bus_req && !done) run_len++;
        else if (run_len > 0) begin
            w_cnt++;
            if (run_len != cur_settle + 1) w_bad++;
            run_len = 0;
        end
        if (!rst && done) done_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [38:0] e);
        exp_log[exp_n] = e;
        exp_n++;
    endtask

    task automatic predict(input bit en, input bit dis, input int n, input logic [31:0] b);
        bit all, good;
        exp_n = 0; exp_waits = 0; all = 1; good = 1;
        if (en) begin
            for (int i = 0; i < n; i++) begin all &= pg[i]; push(ent(i, 0, S_STAT, 0)); end
            if (all) begin exp_pass = 1; paged_m = 1; end
            else begin
                for (int i = 0; i < n; i++) push(ent(i, 1, S_CMD, 2));
                for (int i = 0; i < n; i++) push(ent(i, 1, S_CMD, 6));
                for (int i = 0; i < n; i++) begin
                    push(ent(i, 1, S_BASE, b)); push(ent(i, 1, S_CMD, 4)); push(ent(i, 1, S_IRQ, 3));
                end
                for (int i = 0; i < n; i++) push(ent(i, 1, S_CMD, 0));
                for (int i = 0; i < n; i++) push(ent(i, 1, S_CMD, 3));
                for (int i = 0; i < n; i++) begin push(ent(i, 0, S_STAT, 0)); good &= !broken[i]; end
                exp_pass = good; paged_m = good; exp_waits = 5;
            end
        end else if (dis) begin
            if (!paged_m) exp_pass = 1;
            else begin
                push(ent(0, 0, S_BASE, 0));
                if (sbase[0] == 0) exp_pass = 0;
                else begin
                    for (int i = 0; i < n; i++) push(ent(i, 1, S_CMD, 2));
                    for (int i = 0; i < n; i++) push(ent(i, 1, S_CMD, 1));
                    for (int i = 0; i < n; i++) push(ent(i, 1, S_CMD, 3));
                    exp_pass = 1; paged_m = 0; exp_waits = 3;
                end
            end
        end
    endtask

    task automatic run(input bit en, input bit dis, input int cnt, input int settle,
                       input logic [31:0] b, input bit inject, input string tag);
        int n, mism, guard;
        n = (cnt == 0) ? 1 : (cnt > N ? N : cnt);
        predict(en, dis, n, b);
        @(negedge clk);
        act_n = 0; w_cnt = 0; w_bad = 0; done_cnt = 0; cur_settle = settle;
        en_req = en; dis_req = dis; inst_cnt = 3'(cnt);
        settle_cycles = 16'(settle); base_val = b;
        @(negedge clk);
        en_req = 0; dis_req = 0;
        chk(busy == 1'b1, "R10", {tag, " busy after request"}, busy, 1);
        if (inject && exp_n > 0) begin
            en_req = 1; dis_req = 1;
            @(negedge clk);
            en_req = 0; dis_req = 0;
        end
        guard = 0;
        while (!done && guard < 20000) begin @(negedge clk); guard++; end
        chk(pass == exp_pass, tag, "pass flag", pass, exp_pass);
        @(negedge clk);
        chk(!done && !busy, "R10", {tag, " done one cycle then idle"}, {done, busy}, 0);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R11", {tag, " single done pulse"}, done_cnt, 1);
        chk(act_n == exp_n, tag, "access count", act_n, exp_n);
        mism = -1;
        for (int i = 0; i < exp_n && i < act_n; i++)
            if (mism < 0 && act_log[i] != exp_log[i]) mism = i;
        if (mism >= 0) chk(0, tag, "access sequence", act_log[mism], exp_log[mism]);
        else chk(1, tag, "access sequence", 0, 0);
        chk(w_cnt == exp_waits && w_bad == 0, "R4", {tag, " settle gaps"},
            {w_cnt, w_bad}, {exp_waits, 0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !bus_req, "R1", "reset state", {busy, done, bus_req}, 0);

        run(0, 1, 4, 2, 32'h1000, 0, "R6 disable unpaged");
        run(1, 0, 4, 3, 32'hABC0, 1, "R3 R5 R9 R11 enable");
        run(1, 0, 4, 1, 32'hABC0, 0, "R2 already paged");
        sbase[0] = 0;
        run(0, 1, 4, 2, 32'h0, 0, "R7 zero base");
        sbase[0] = 32'h55;
        run(0, 1, 4, 0, 32'h0, 1, "R8 disable");
        broken[2] = 1;
        run(1, 0, 4, 2, 32'h7700, 0, "R5 broken instance");
        broken[2] = 0;
        run(1, 0, 0, 1, 32'h1234, 0, "R13 count zero");
        run(0, 1, 7, 1, 32'h0, 0, "R13 count clamp disable");
        for (int i = 0; i < N; i++) pg[i] = 0;
        run(1, 1, 7, 2, 32'h4321, 0, "R12 both requests");

        for (int k = 0; k < 40; k++) begin
            int op;
            op = int'($urandom % 4);
            for (int i = 0; i < N; i++) broken[i] = ($urandom % 6 == 0);
            if (paged_m && ($urandom % 8 == 0)) sbase[0] = 0;
            if ($urandom % 5 == 0) for (int i = 0; i < N; i++) pg[i] = 0;
            run(op != 2, op >= 2, int'($urandom % 6), int'($urandom % 4),
                $urandom | 32'h1, $urandom % 2 == 1, "R3 R8 R13 random");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule